// File: doc/BRIEF.md
# Start-up Supervision State Machine

This block decides what the system does once a reset has been released. After any reset it sits in a start-up mode. When the reset line is both released by the pulse stretcher and sensed high, a window of 256 one-millisecond ticks opens. Software must initialise the watchdog inside that window. If it does, the block moves to Normal mode, or to Flash mode when a flash preparation is pending.

The first missed window sends the block through a one-cycle Restart mode. In that cycle it asks the pulse stretcher for a long reset and asks the supply monitor to raise its undervoltage threshold. After that, a second window is granted. A second miss, or a reset line that stays low for 256 ticks after release, drives the block into Fail-safe. Only an explicit wake-up input leaves Fail-safe, and it starts over with a clean attempt count.

Top module: `startup_supervisor`

## Requirements
- R1: After `rst_n` is deasserted, `mode` is 0 (start-up) and both request outputs are low. The mode encoding is 0 start-up, 1 normal, 2 flash, 3 restart, 4 fail-safe.
- R2: While `rst_released` is low, ticks have no effect, and the block stays in mode 0 however many ticks arrive.
- R3: In mode 0, a `wdg_init` pulse while the line is released and high moves to mode 1 if `flash_pending` is low, or to mode 2 if it is high.
- R4: On the first attempt, the 256th tick counted with the line released and high moves the block to mode 3 on that clock edge. Mode 3 lasts one cycle, and the block then returns to mode 0 with a fresh window.
- R5: When the window expires on the second attempt, the block moves to mode 4.
- R6: In mode 0, if the line is released but sensed low for 256 ticks, the block moves to mode 4. The attempt count does not matter.
- R7: Entering mode 1 or 2 clears the attempt count, so a later window expiry leads to mode 3 again.
- R8: Mode 4 is left only when `wake` is high, which moves the block to mode 0 with the attempt count at zero. `reset_event` and `wdg_init` have no effect in mode 4.
- R9: A `reset_event` pulse in mode 1 or mode 2 moves the block to mode 0.
- R10: `restart_req` and `thr_high_req` are high exactly while the block is in mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| rst_released | input | 1 | The pulse stretcher is no longer driving the reset line |
| line_level | input | 1 | Sensed level of the reset line |
| wdg_init | input | 1 | Pulse: the watchdog has been initialised |
| flash_pending | input | 1 | Flash preparation is complete |
| reset_event | input | 1 | Pulse: a new reset occurred |
| wake | input | 1 | Wake-up request that releases fail-safe |
| mode | output | 3 | Current mode, encoded as in R1 |
| restart_req | output | 1 | Request for a long reset pulse |
| thr_high_req | output | 1 | Request to set the undervoltage threshold high |

## Verification
The bench counts the window to the exact tick, checking the state after 255 ticks and again after 256. A timer that is off by one would leave start-up one tick early or one tick late. It also checks that the attempt count is cleared both by a successful start and by a wake from fail-safe. A design that keeps the count would escalate straight to fail-safe on the next missed window, where a restart is required. Held-reset ticks and a clamped low line are driven separately, which exposes a design that counts the window before release or that sends a clamp through a restart.

// File: rtl/startup_supervisor.sv
module startup_supervisor #(
  parameter int WINDOW = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1ms,
  input  logic       rst_released,
  input  logic       line_level,
  input  logic       wdg_init,
  input  logic       flash_pending,
  input  logic       reset_event,
  input  logic       wake,
  output logic [2:0] mode,
  output logic       restart_req,
  output logic       thr_high_req
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [2:0] M_START = 3'd0, M_NORMAL = 3'd1, M_FLASH = 3'd2,
                         M_RESTART = 3'd3, M_FAILSAFE = 3'd4;

  logic          attempt;
  logic [CW-1:0] win_cnt, clamp_cnt;

  wire line_up  = rst_released && line_level;
  wire line_low = rst_released && !line_level;
  wire win_to   = line_up  && tick_1ms && (win_cnt   == CW'(WINDOW - 1));
  wire clamp_to = line_low && tick_1ms && (clamp_cnt == CW'(WINDOW - 1));

  assign restart_req  = (mode == M_RESTART);
  assign thr_high_req = (mode == M_RESTART);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= M_START;
      attempt <= 1'b0;
    end else begin
      case (mode)
        M_START: begin
          if (clamp_to) mode <= M_FAILSAFE;
          else if (line_up && wdg_init) begin
            mode    <= flash_pending ? M_FLASH : M_NORMAL;
            attempt <= 1'b0;
          end else if (win_to) begin
            if (attempt) mode <= M_FAILSAFE;
            else begin
              mode    <= M_RESTART;
              attempt <= 1'b1;
            end
          end
        end
        M_NORMAL, M_FLASH: if (reset_event) mode <= M_START;
        M_RESTART: mode <= M_START;
        M_FAILSAFE: if (wake) begin
          mode    <= M_START;
          attempt <= 1'b0;
        end
        default: mode <= M_START;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt   <= '0;
      clamp_cnt <= '0;
    end else if (mode != M_START) begin
      win_cnt   <= '0;
      clamp_cnt <= '0;
    end else begin
      if (line_up && tick_1ms) win_cnt <= win_cnt + 1'b1;
      if (!line_low) clamp_cnt <= '0;
      else if (tick_1ms) clamp_cnt <= clamp_cnt + 1'b1;
    end
  end

  assert_restart_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_RESTART |=> mode == M_START);

  assert_failsafe_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_FAILSAFE && !wake) |=> mode == M_FAILSAFE);

  assert_normal_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NORMAL && $past(mode) == M_START) |-> ($past(wdg_init) && !$past(flash_pending)));

  assert_failsafe_from_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_FAILSAFE && $past(mode) != M_FAILSAFE) |-> $past(mode) == M_START);

  assert_restart_first_try_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restart_req) |-> ($past(mode) == M_START && !$past(attempt)));

  assert_window_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= CW'(WINDOW));
endmodule

// File: tb/sim_startup_supervisor.sv
module sim_startup_supervisor;
  logic clk = 0, rst_n = 0, tick_1ms = 0, rst_released = 0, line_level = 0;
  logic wdg_init = 0, flash_pending = 0, reset_event = 0, wake = 0;
  logic [2:0] mode;
  logic restart_req, thr_high_req;
  int checks = 0, errors = 0;

  startup_supervisor u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; tick_1ms = 0; rst_released = 0; line_level = 0;
    wdg_init = 0; flash_pending = 0; reset_event = 0; wake = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_1ms = 1;
      @(negedge clk) tick_1ms = 0;
    end
  endtask

  task automatic pulse_init();
    @(negedge clk) wdg_init = 1;
    @(negedge clk) wdg_init = 0;
  endtask

  task automatic pulse_rst_event();
    @(negedge clk) reset_event = 1;
    @(negedge clk) reset_event = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 mode", mode, 0);
    chk("R1 restart_req", restart_req, 0);
    chk("R10 thr_high_req", thr_high_req, 0);
  endtask

  task automatic t_held();
    do_reset();
    ticks(300);
    chk("R2 held ticks", mode, 0);
  endtask

  task automatic t_success();
    do_reset();
    rst_released = 1; line_level = 1;
    ticks(100);
    pulse_init();
    chk("R3 normal", mode, 1);
    pulse_rst_event();
    chk("R9 from normal", mode, 0);
    flash_pending = 1;
    pulse_init();
    chk("R3 flash", mode, 2);
    flash_pending = 0;
    pulse_rst_event();
    chk("R9 from flash", mode, 0);
  endtask

  task automatic t_expiry();
    do_reset();
    rst_released = 1; line_level = 1;
    ticks(255);
    chk("R4 before window end", mode, 0);
    ticks(1);
    chk("R4 restart", mode, 3);
    chk("R10 restart_req", restart_req, 1);
    chk("R10 thr_high_req", thr_high_req, 1);
    @(negedge clk);
    chk("R4 back to start", mode, 0);
    chk("R10 restart_req low", restart_req, 0);
    ticks(255);
    chk("R5 before second end", mode, 0);
    ticks(1);
    chk("R5 failsafe", mode, 4);
    pulse_rst_event();
    pulse_init();
    chk("R8 ignores events", mode, 4);
    @(negedge clk) wake = 1;
    @(negedge clk) wake = 0;
    chk("R8 wake", mode, 0);
    ticks(256);
    chk("R8 attempt cleared", mode, 3);
  endtask

  task automatic t_attempt_clear();
    do_reset();
    rst_released = 1; line_level = 1;
    ticks(256);
    chk("R7 first restart", mode, 3);
    @(negedge clk);
    pulse_init();
    chk("R7 normal", mode, 1);
    pulse_rst_event();
    ticks(256);
    chk("R7 restart again", mode, 3);
  endtask

  task automatic t_clamp();
    do_reset();
    rst_released = 1; line_level = 0;
    ticks(255);
    chk("R6 before clamp limit", mode, 0);
    ticks(1);
    chk("R6 clamp failsafe", mode, 4);
  endtask

  initial begin
    t_reset_state();
    t_held();
    t_success();
    t_expiry();
    t_attempt_clear();
    t_clamp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule